// File: doc/BRIEF.md
# Timed GPIO Instruction Executor

This block takes one already-assembled 52-bit command and turns it into timed activity on a bank of 32 general-purpose lines. A command either raises one line for a programmed number of clock cycles, samples one line after a programmed delay, or raises a scattered set of lines chosen by eight independent 5-bit selectors. Two command variants first spend a parameterized "one second" of idle time before acting. The block executes one command at a time and reports that it is occupied through a busy flag.

A host-side front end supplies the command word with a one-cycle valid strobe. While the block is idle, a recognised command is accepted on the clock edge where the strobe is high. All driven lines are low whenever no command is in progress. A read produces a one-cycle result strobe that carries the sampled bit. The length of one second is the parameter `ONE_SEC_CYC`, which is a count of clock cycles.

Top module: `gce_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gpio_out` is all zero and `busy` and `rd_valid` are 0.
- R2: Opcode 3'b000 (command bits [51:49]) drives 1 on the line indexed by the primary field [48:44]. The line goes high from the cycle after acceptance and stays high for N cycles, where N is the auxiliary field [43:0]. All lines are then 0 again, and `busy` is high for exactly those N cycles.
- R3: Opcode 3'b001 first keeps `busy` high with all lines 0 for `ONE_SEC_CYC` cycles. It then behaves as R2.
- R4: Opcode 3'b100 keeps `busy` high with all lines 0 for N cycles (N = auxiliary field). On the edge that ends them, `busy` falls and `rd_valid` pulses for one cycle with `rd_bit` equal to `gpio_in` at the primary-field index.
- R5: Opcode 3'b011 is a scattered write of value bits [7:0]. Value bit 0 goes to the line given by the primary field [48:44]. Value bit i (i = 1..7) goes to the line given by auxiliary bits [9+5(i-1)+4 : 9+5(i-1)], so bit 7 uses [43:39] and bit 1 uses [13:9]. Bit 8 is unused. The pattern is held for one cycle.
- R6: In a scattered write, a line is 1 when any value bit routed to it is 1. Every line not so raised is 0.
- R7: Opcode 3'b111 keeps `busy` high with lines 0 for `ONE_SEC_CYC` cycles. It then holds the R5 pattern for `ONE_SEC_CYC` cycles.
- R8: A command strobed while `busy` is high is ignored: the running pattern, its length and any read result are unchanged.
- R9: Opcodes 3'b010, 3'b101 and 3'b110 are ignored. `busy` stays 0 and all lines stay 0.
- R10: An auxiliary count of 0 on opcodes 3'b000, 3'b001 and 3'b100 acts as a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled on the rising edge |
| cmd_word | input | 52 | Command: opcode [51:49], primary [48:44], auxiliary [43:0] |
| gpio_in | input | 32 | Line input values, sampled by reads |
| gpio_out | output | 32 | Line drive values |
| busy | output | 1 | High while a command is running |
| rd_valid | output | 1 | One-cycle strobe carrying a read result |
| rd_bit | output | 1 | Sampled line value, valid with `rd_valid` |

## Verification
The embedded properties assume that `ONE_SEC_CYC` is at least 1 and that `cmd_word` only matters on cycles where `cmd_valid` is high. They place no constraint on commands arriving while the block is busy. The stimulus keeps `gpio_in` constant from acceptance until the read strobe, so the sampled bit is known. It uses a small one-second count so that pre-waits and second-long holds fit inside short runs, and it deliberately strobes commands during a hold and with undefined opcodes.

// File: rtl/gce_pkg.sv
package gce_pkg;

    localparam int CMD_W   = 52;
    localparam int OP_W    = 3;
    localparam int REG_W   = 5;
    localparam int AUX_W   = 44;
    localparam int LINES   = 1 << REG_W;
    localparam int SCAT_N  = 8;
    localparam int SEL_LO  = 9;    // lowest auxiliary bit of selector for value bit 1

    typedef enum logic [OP_W-1:0] {
        OP_HOLD      = 3'b000,
        OP_WAIT_HOLD = 3'b001,
        OP_SCATTER   = 3'b011,
        OP_SAMPLE    = 3'b100,
        OP_WAIT_SCAT = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_ACT
    } phase_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] prim;
        logic [AUX_W-1:0] aux;
    } cmd_t;

    typedef struct packed {
        logic             ok;      // recognised opcode
        logic             pre;     // one-second pre-wait first
        logic             rd;      // sampling command
        logic [REG_W-1:0] line;    // line for single-bit commands
        logic [AUX_W-1:0] len;     // active phase length in cycles (>= 1)
        logic [LINES-1:0] pat;     // drive pattern during the active phase
    } plan_t;

    // Zero counts are treated as one cycle.
    function automatic logic [AUX_W-1:0] at_least_one(input logic [AUX_W-1:0] n);
        return (n == '0) ? AUX_W'(1) : n;
    endfunction

    function automatic logic [LINES-1:0] one_hot_line(input logic [REG_W-1:0] idx);
        logic [LINES-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/gce_decoder.sv
module gce_decoder
    import gce_pkg::*;
#(
    parameter int unsigned ONE_SEC_CYC = 50_000_000
) (
    input  cmd_t  cmd,
    output plan_t plan
);

    localparam logic [AUX_W-1:0] SEC_LEN = AUX_W'(ONE_SEC_CYC);

    logic [REG_W-1:0] sel  [SCAT_N];
    logic [LINES-1:0] part [SCAT_N];
    logic [LINES-1:0] scat_pat;
    logic [SCAT_N-1:0] value;

    assign value = cmd.aux[SCAT_N-1:0];
    assign sel[0] = cmd.prim;

    genvar gi;
    generate
        for (gi = 1; gi < SCAT_N; gi++) begin : g_sel
            assign sel[gi] = cmd.aux[SEL_LO + REG_W*(gi-1) +: REG_W];
        end
        for (gi = 0; gi < SCAT_N; gi++) begin : g_part
            assign part[gi] = value[gi] ? one_hot_line(sel[gi]) : '0;
        end
    endgenerate

    always_comb begin
        scat_pat = '0;
        for (int i = 0; i < SCAT_N; i++) begin
            scat_pat = scat_pat | part[i];
        end
    end

    always_comb begin
        plan      = '0;
        plan.line = cmd.prim;
        unique case (cmd.op)
            OP_HOLD: begin
                plan.ok  = 1'b1;
                plan.len = at_least_one(cmd.aux);
                plan.pat = one_hot_line(cmd.prim);
            end
            OP_WAIT_HOLD: begin
                plan.ok  = 1'b1;
                plan.pre = 1'b1;
                plan.len = at_least_one(cmd.aux);
                plan.pat = one_hot_line(cmd.prim);
            end
            OP_SAMPLE: begin
                plan.ok  = 1'b1;
                plan.rd  = 1'b1;
                plan.len = at_least_one(cmd.aux);
            end
            OP_SCATTER: begin
                plan.ok  = 1'b1;
                plan.len = AUX_W'(1);
                plan.pat = scat_pat;
            end
            OP_WAIT_SCAT: begin
                plan.ok  = 1'b1;
                plan.pre = 1'b1;
                plan.len = SEC_LEN;
                plan.pat = scat_pat;
            end
            default: plan = '0;
        endcase
    end

    always_comb begin
        AST_LEN_NONZERO: assert (!plan.ok || plan.len != '0); // R10
        AST_READ_NO_DRIVE: assert (!plan.rd || plan.pat == '0); // R4
    end

endmodule

// File: rtl/gce_sequencer.sv
module gce_sequencer
    import gce_pkg::*;
#(
    parameter int unsigned ONE_SEC_CYC = 50_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  plan_t            plan,
    output logic             busy,
    output logic [LINES-1:0] drive,
    output logic             sample_now,
    output logic [REG_W-1:0] sample_line
);

    localparam logic [AUX_W-1:0] SEC_LEN = AUX_W'(ONE_SEC_CYC);

    phase_e           phase_q;
    logic [AUX_W-1:0] cnt_q;
    logic [AUX_W-1:0] len_q;
    logic [LINES-1:0] pat_q;
    logic [LINES-1:0] drive_q;
    logic             rd_q;
    logic [REG_W-1:0] line_q;
    logic             accept;
    logic             last;

    assign accept = cmd_valid && plan.ok && (phase_q == PH_IDLE);
    assign last   = (cnt_q == AUX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            pat_q   <= '0;
            drive_q <= '0;
            rd_q    <= 1'b0;
            line_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        len_q  <= plan.len;
                        pat_q  <= plan.pat;
                        rd_q   <= plan.rd;
                        line_q <= plan.line;
                        if (plan.pre) begin
                            phase_q <= PH_PRE;
                            cnt_q   <= SEC_LEN;
                        end else begin
                            phase_q <= PH_ACT;
                            cnt_q   <= plan.len;
                            drive_q <= plan.pat;
                        end
                    end
                end
                PH_PRE: begin
                    if (last) begin
                        phase_q <= PH_ACT;
                        cnt_q   <= len_q;
                        drive_q <= pat_q;
                    end else begin
                        cnt_q <= cnt_q - AUX_W'(1);
                    end
                end
                PH_ACT: begin
                    if (last) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        drive_q <= '0;
                    end else begin
                        cnt_q <= cnt_q - AUX_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy        = (phase_q != PH_IDLE);
    assign drive       = drive_q;
    assign sample_now  = (phase_q == PH_ACT) && last && rd_q;
    assign sample_line = line_q;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> drive == '0); // R1
    AST_PRE_QUIET: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_PRE |-> drive == '0); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACT && $past(phase_q) == PH_ACT) |-> $stable(drive)); // R8
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> cnt_q == $past(cnt_q) - AUX_W'(1)); // R8
    AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && !plan.ok) |=> !busy); // R9
    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt_q != '0); // R10

endmodule

// File: rtl/gce_readback.sv
module gce_readback
    import gce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_now,
    input  logic [REG_W-1:0] sample_line,
    input  logic [LINES-1:0] gpio_in,
    output logic             rd_valid,
    output logic             rd_bit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= sample_now;
            if (sample_now) begin
                rd_bit <= gpio_in[sample_line];
            end
        end
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R4
    AST_RD_VALUE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_bit == $past(gpio_in[sample_line])); // R4

endmodule

// File: rtl/gce_top.sv
module gce_top
    import gce_pkg::*;
#(
    parameter int unsigned ONE_SEC_CYC = 50_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [51:0] cmd_word,
    input  logic [31:0] gpio_in,
    output logic [31:0] gpio_out,
    output logic        busy,
    output logic        rd_valid,
    output logic        rd_bit
);

    cmd_t             cmd;
    plan_t            plan;
    logic             sample_now;
    logic [REG_W-1:0] sample_line;

    assign cmd = cmd_t'(cmd_word);

    gce_decoder #(.ONE_SEC_CYC(ONE_SEC_CYC)) u_dec (
        .cmd  (cmd),
        .plan (plan)
    );

    gce_sequencer #(.ONE_SEC_CYC(ONE_SEC_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .plan        (plan),
        .busy        (busy),
        .drive       (gpio_out),
        .sample_now  (sample_now),
        .sample_line (sample_line)
    );

    gce_readback u_rb (
        .clk         (clk),
        .rst         (rst),
        .sample_now  (sample_now),
        .sample_line (sample_line),
        .gpio_in     (gpio_in),
        .rd_valid    (rd_valid),
        .rd_bit      (rd_bit)
    );

    initial begin
        AST_SEC_POSITIVE: assert (ONE_SEC_CYC >= 1); // R3
    end

    AST_RD_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !busy); // R4

endmodule

// File: tb/gce_top_tb_top.sv
`timescale 1ns/1ps
module gce_top_tb_top;

    localparam int unsigned SEC = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [51:0] cmd_word = '0;
    logic [31:0] gpio_in = '0;
    logic [31:0] gpio_out;
    logic        busy;
    logic        rd_valid;
    logic        rd_bit;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    gce_top #(.ONE_SEC_CYC(SEC)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .gpio_in   (gpio_in),
        .gpio_out  (gpio_out),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_bit    (rd_bit)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  prim;
        logic [43:0] aux;
        logic [31:0] gin;
        logic [7:0]  pre;
        logic [7:0]  len;
        logic [31:0] pat;
        logic        rd;
        logic        bitv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'b000, 5'd3,  44'd4, 32'h0,        8'd0, 8'd4, 32'h0000_0008, 1'b0, 1'b0}, // R2
        '{3'b000, 5'd31, 44'd0, 32'h0,        8'd0, 8'd1, 32'h8000_0000, 1'b0, 1'b0}, // R10
        '{3'b001, 5'd0,  44'd2, 32'h0,        8'd5, 8'd2, 32'h0000_0001, 1'b0, 1'b0}, // R3
        '{3'b100, 5'd7,  44'd3, 32'h0000_0080, 8'd0, 8'd3, 32'h0,        1'b1, 1'b1}, // R4
        '{3'b100, 5'd20, 44'd0, 32'hFFEF_FFFF, 8'd0, 8'd1, 32'h0,        1'b1, 1'b0}, // R4 R10
        '{3'b011, 5'd24, {5'd31,5'd30,5'd29,5'd28,5'd27,5'd26,5'd25,1'b0,8'hA5},
          32'h0, 8'd0, 8'd1, 32'hA500_0000, 1'b0, 1'b0},                              // R5
        '{3'b011, 5'd5,  {5'd10,5'd10,5'd10,5'd10,5'd10,5'd10,5'd5,1'b0,8'h02},
          32'h0, 8'd0, 8'd1, 32'h0000_0020, 1'b0, 1'b0},                              // R6
        '{3'b111, 5'd0,  {5'd7,5'd6,5'd5,5'd4,5'd3,5'd2,5'd1,1'b0,8'h3C},
          32'h0, 8'd5, 8'd5, 32'h0000_003C, 1'b0, 1'b0}                               // R7
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [4:0] prim,
                         input logic [43:0] aux, input logic [31:0] gin);
        cmd_word  = {op, prim, aux};
        gpio_in   = gin;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        bit ok;
        logic [31:0] bad;
        issue(v.op, v.prim, v.aux, v.gin);
        ok = 1'b1; bad = '0;
        for (int k = 0; k < int'(v.pre); k++) begin
            if (!busy || gpio_out != '0) begin ok = 1'b0; bad = gpio_out; end
            @(negedge clk);
        end
        check(ok, req, "pre-wait quiet with busy", 64'(bad), 64'h0);
        ok = 1'b1; bad = v.pat;
        for (int k = 0; k < int'(v.len); k++) begin
            if (!busy || gpio_out != v.pat || rd_valid) begin ok = 1'b0; bad = gpio_out; end
            @(negedge clk);
        end
        check(ok, req, "active pattern", 64'(bad), 64'(v.pat));
        check(!busy && gpio_out == '0, req, "released after length",
              64'({busy, gpio_out}), 64'h0);
        check(rd_valid == v.rd, req, "read strobe", 64'(rd_valid), 64'(v.rd));
        if (v.rd)
            check(rd_bit == v.bitv, req, "read value", 64'(rd_bit), 64'(v.bitv));
        @(negedge clk);
        check(!rd_valid, req, "read strobe one cycle", 64'(rd_valid), 64'h0);
    endtask

    initial begin
        #(5.0 * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        logic [31:0] bad;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(gpio_out == '0 && !busy && !rd_valid, "R1", "reset outputs",
              64'({busy, rd_valid, gpio_out}), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(gpio_out == '0 && !busy && !rd_valid, "R1", "first cycle after reset",
              64'({busy, rd_valid, gpio_out}), 64'h0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], $sformatf("vector%0d", i));
        end

        // R9: undefined opcodes
        for (int j = 0; j < 3; j++) begin
            logic [2:0] bop;
            bop = (j == 0) ? 3'b010 : (j == 1) ? 3'b101 : 3'b110;
            issue(bop, 5'd4, 44'd3, 32'h0);
            check(!busy && gpio_out == '0, "R9", "undefined opcode ignored",
                  64'({busy, gpio_out}), 64'h0);
        end

        // R8: command during a hold is ignored
        issue(3'b000, 5'd3, 44'd6, 32'h0);
        ok = 1'b1; bad = 32'h8;
        for (int k = 0; k < 6; k++) begin
            if (k == 2) begin
                cmd_word = {3'b011, 5'd9, {5'd9,5'd9,5'd9,5'd9,5'd9,5'd9,5'd9,1'b0,8'hFF}};
                cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            if (!busy || gpio_out != 32'h8) begin ok = 1'b0; bad = gpio_out; end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(ok, "R8", "hold unchanged by busy command", 64'(bad), 64'h8);
        check(!busy && gpio_out == '0, "R8", "ends at original length",
              64'({busy, gpio_out}), 64'h0);
        @(negedge clk);
        check(!busy && gpio_out == '0, "R8", "ignored command left no work",
              64'({busy, gpio_out}), 64'h0);

        // R8: read result unaffected by command during its delay
        issue(3'b100, 5'd12, 44'd4, 32'h0000_1000);
        cmd_word = {3'b100, 5'd0, 44'd1};
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_valid && rd_bit && !busy, "R8", "read kept original line and delay",
              64'({rd_valid, rd_bit, busy}), 64'h6);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule